// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the exception entry step of a simple 32-bit core. Each cycle the pipeline presents a vector of fault requests, along with the program counter of the faulting instruction and the program counter that follows it. When any request is raised, the block picks one winner by fixed priority. It updates the coprocessor-0 state it owns: Status, Cause, EPC and the shadow register-set control word. It then emits a one-cycle redirect with the handler address. The pipeline must flush whenever that redirect pulse is seen.

Reset, soft reset and the non-maskable interrupt all send the core to the boot reset address and leave the saved exception state untouched. Every other fault records its cause, whether it sat in a branch delay slot, and its restart address. Those faults enter kernel mode by setting the exception level bit. They rotate the shadow register sets only when the core was neither already at exception level nor running from the boot vectors. The core's move-to-coprocessor path writes these registers through a small write port, and reads them back through a combinational read port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After rst_n is released, Status reads 0x0040_0000 and Cause, EPC and shadow-set control all read zero, and redirect_valid is low. Read select 0 returns Status, 1 returns Cause, 2 returns EPC and 3 returns shadow-set control. Status fields: CU1 is bit 29, BEV is bit 22, EXL is bit 1. Cause fields: BD is bit 31, CE is bits 29:28, ExcCode is bits 6:2. Shadow-set control fields: ESS is bits 15:12, PSS is bits 9:6, CSS is bits 3:0.
- R2: fault_req bit positions give the priority, and the lowest set bit wins. The positions are: 0 reset, 1 soft reset, 2 NMI, 3 machine check, 4 TLB refill, 5 TLB invalid, 6 address error, 7 coprocessor unusable, 8 reserved instruction, 9 syscall, 10 breakpoint, 11 trap, 12 overflow, 13 TLB modified, 14 DSP disabled, 15 thread, 16 interrupt.
- R3: Every entry that is not of the reset kind sets Status.EXL to 1, including an entry that arrives while EXL is already 1.
- R4: An instruction is in a delay slot when fault_npc differs from fault_pc + 4. In that case EPC receives fault_pc − 4 and Cause.BD becomes 1. Otherwise EPC receives fault_pc and BD becomes 0.
- R5: On every entry that is not of the reset kind, Cause.CE is cleared and ExcCode is loaded with the winner's code. The codes are: interrupt 0, TLB modified 1, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24. The remaining faults take the parameter DEFAULT_CODE, which is 30 by default.
- R6: Shadow sets rotate (PSS takes CSS, CSS takes ESS) only when both EXL and BEV were 0 before the entry. Otherwise PSS and CSS keep their values.
- R7: For the faults that are not of the reset kind, redirect_pc is a base plus an offset. The base is 0x8000_0000 when BEV was 0 and 0xBFC0_0200 when BEV was 1. The offset is 0x000 for an interrupt and 0x180 for every other such fault.
- R8: Reset, soft reset and NMI redirect to 0xBFC0_0000 and leave EPC, Cause, shadow-set control and EXL unchanged. Only reset also sets Status.CU1.
- R9: redirect_valid is high for exactly the one cycle after the clock edge that sampled a request, and the register updates land on that same edge. A cycle with no request produces no pulse.
- R10: A write selects its register with cp0_wr_sel, using the R1 encoding. It updates CU1, BEV and EXL of Status, all of EPC, or ESS, PSS and CSS of shadow-set control. Cause ignores writes. A write in a cycle that also takes a request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 17 | Fault request vector, one bit per fault kind |
| fault_pc | input | 32 | PC of the faulting instruction |
| fault_npc | input | 32 | PC that follows the faulting instruction |
| cp0_wr_en | input | 1 | Coprocessor-0 write strobe |
| cp0_wr_sel | input | 2 | Register selected for writing |
| cp0_wr_data | input | 32 | Write data |
| cp0_rd_sel | input | 2 | Register selected for reading |
| cp0_rd_data | output | 32 | Read data, combinational from the registers |
| redirect_valid | output | 1 | One-cycle flush and redirect pulse |
| redirect_pc | output | 32 | Handler address |

## Verification
A request applied at a falling edge is sampled at the next rising edge. redirect_valid and redirect_pc are due one register stage later, so the bench checks them at the falling edge that follows, before the next rising edge can clear the pulse. The register updates land on that same edge, and the read port is combinational. Each scenario therefore reads the registers after the pulse has been checked, stepping the read select a nanosecond at a time, and checks one cycle later that the pulse has dropped. Writes are checked the same way, one edge after the strobe.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Bit position in the request vector; lower value wins.
    typedef enum logic [4:0] {
        EK_RESET         = 5'd0,
        EK_SOFT_RESET    = 5'd1,
        EK_NMI           = 5'd2,
        EK_MCHECK        = 5'd3,
        EK_TLB_REFILL    = 5'd4,
        EK_TLB_INVALID   = 5'd5,
        EK_ADDR_ERR      = 5'd6,
        EK_CP_UNUSABLE   = 5'd7,
        EK_RESERVED_INSN = 5'd8,
        EK_SYSCALL       = 5'd9,
        EK_BREAK         = 5'd10,
        EK_TRAP          = 5'd11,
        EK_OVERFLOW      = 5'd12,
        EK_TLB_MOD       = 5'd13,
        EK_DSP_OFF       = 5'd14,
        EK_THREAD        = 5'd15,
        EK_INTERRUPT     = 5'd16
    } exc_kind_e;

    localparam int NUM_KINDS = 17;
    localparam int KIND_W    = $clog2(NUM_KINDS);

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_CAUSE  = 2'd1;
    localparam logic [1:0] SEL_EPC    = 2'd2;
    localparam logic [1:0] SEL_SRS    = 2'd3;

    function automatic logic [4:0] kind_code(exc_kind_e k, logic [4:0] dflt);
        case (k)
            EK_INTERRUPT:     return 5'd0;
            EK_TLB_MOD:       return 5'd1;
            EK_SYSCALL:       return 5'd8;
            EK_BREAK:         return 5'd9;
            EK_RESERVED_INSN: return 5'd10;
            EK_CP_UNUSABLE:   return 5'd11;
            EK_OVERFLOW:      return 5'd12;
            EK_TRAP:          return 5'd13;
            EK_MCHECK:        return 5'd24;
            default:          return dflt;
        endcase
    endfunction

    function automatic logic kind_resetlike(exc_kind_e k);
        return (k == EK_RESET) || (k == EK_SOFT_RESET) || (k == EK_NMI);
    endfunction

    function automatic logic kind_low_offset(exc_kind_e k);
        return (k == EK_INTERRUPT);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
    parameter int N = 17,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        // Scan from the top so the lowest set bit is written last.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/exc_cp0.sv
module exc_cp0 import exc_pkg::*; #(
    parameter logic [4:0]  DEFAULT_CODE = 5'd30,
    parameter int          SET_W        = 4,
    parameter logic [31:0] RUN_BASE     = 32'h8000_0000,
    parameter logic [31:0] BOOT_BASE    = 32'hBFC0_0200,
    parameter logic [31:0] RESET_VEC    = 32'hBFC0_0000,
    parameter logic [31:0] GEN_OFFSET   = 32'h0000_0180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  exc_kind_e   kind,
    input  logic [31:0] pc,
    input  logic [31:0] npc,
    input  logic        we,
    input  logic [1:0]  wsel,
    input  logic [31:0] wdata,
    input  logic [1:0]  rsel,
    output logic [31:0] rdata,
    output logic        redir_valid,
    output logic [31:0] redir_pc
);
    localparam int ESS_LSB = 12;
    localparam int PSS_LSB = 6;
    localparam int CSS_LSB = 0;
    localparam int CU1_BIT = 29;
    localparam int BEV_BIT = 22;
    localparam int EXL_BIT = 1;

    typedef struct packed {
        logic             cu1;
        logic             bev;
        logic             exl;
        logic             bd;
        logic [1:0]       ce;
        logic [4:0]       code;
        logic [31:0]      epc;
        logic [SET_W-1:0] ess;
        logic [SET_W-1:0] pss;
        logic [SET_W-1:0] css;
        logic             rv;
        logic [31:0]      rpc;
    } cp0_state_t;

    cp0_state_t st_d, st_q;
    logic       in_slot;
    logic       rl;

    assign in_slot = (npc != pc + 32'd4);
    assign rl      = kind_resetlike(kind);

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (take) begin
            st_d.rv = 1'b1;
            if (rl) begin
                st_d.rpc = RESET_VEC;
                if (kind == EK_RESET) st_d.cu1 = 1'b1;
            end else begin
                st_d.exl = 1'b1;
                if (!st_q.exl && !st_q.bev) begin
                    st_d.pss = st_q.css;
                    st_d.css = st_q.ess;
                end
                st_d.epc  = in_slot ? (pc - 32'd4) : pc;
                st_d.bd   = in_slot;
                st_d.ce   = 2'b00;
                st_d.code = kind_code(kind, DEFAULT_CODE);
                st_d.rpc  = (st_q.bev ? BOOT_BASE : RUN_BASE)
                          + (kind_low_offset(kind) ? 32'h0 : GEN_OFFSET);
            end
        end else if (we) begin
            case (wsel)
                SEL_STATUS: begin
                    st_d.cu1 = wdata[CU1_BIT];
                    st_d.bev = wdata[BEV_BIT];
                    st_d.exl = wdata[EXL_BIT];
                end
                SEL_EPC: st_d.epc = wdata;
                SEL_SRS: begin
                    st_d.ess = wdata[ESS_LSB +: SET_W];
                    st_d.pss = wdata[PSS_LSB +: SET_W];
                    st_d.css = wdata[CSS_LSB +: SET_W];
                end
                default: ; // Cause is read-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.bev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            SEL_STATUS: begin
                rdata[CU1_BIT] = st_q.cu1;
                rdata[BEV_BIT] = st_q.bev;
                rdata[EXL_BIT] = st_q.exl;
            end
            SEL_CAUSE: begin
                rdata[31]    = st_q.bd;
                rdata[29:28] = st_q.ce;
                rdata[6:2]   = st_q.code;
            end
            SEL_EPC: rdata = st_q.epc;
            default: begin
                rdata[ESS_LSB +: SET_W] = st_q.ess;
                rdata[PSS_LSB +: SET_W] = st_q.pss;
                rdata[CSS_LSB +: SET_W] = st_q.css;
            end
        endcase
    end

    assign redir_valid = st_q.rv;
    assign redir_pc    = st_q.rpc;

    assert_exl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rl) |=> st_q.exl);

    assert_slot_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rl && in_slot) |=> (st_q.bd && st_q.epc == $past(pc) - 32'd4));

    assert_ce_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rl) |=> (st_q.ce == 2'b00));

    assert_srs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rl && (st_q.exl || st_q.bev)) |=> ($stable(st_q.css) && $stable(st_q.pss)));

    assert_reset_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rl) |=> (st_q.rpc == RESET_VEC && $stable(st_q.epc) && $stable(st_q.code)));

    assert_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !st_q.rv);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl import exc_pkg::*; #(
    parameter logic [4:0]  DEFAULT_CODE = 5'd30,
    parameter int          SET_W        = 4,
    parameter logic [31:0] RUN_BASE     = 32'h8000_0000,
    parameter logic [31:0] BOOT_BASE    = 32'hBFC0_0200,
    parameter logic [31:0] RESET_VEC    = 32'hBFC0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] fault_req,
    input  logic [31:0]          fault_pc,
    input  logic [31:0]          fault_npc,
    input  logic                 cp0_wr_en,
    input  logic [1:0]           cp0_wr_sel,
    input  logic [31:0]          cp0_wr_data,
    input  logic [1:0]           cp0_rd_sel,
    output logic [31:0]          cp0_rd_data,
    output logic                 redirect_valid,
    output logic [31:0]          redirect_pc
);
    logic              take;
    logic [KIND_W-1:0] win_idx;
    exc_kind_e         win_kind;

    exc_prio #(.N(NUM_KINDS)) u_prio (
        .req (fault_req),
        .hit (take),
        .idx (win_idx)
    );

    assign win_kind = exc_kind_e'(win_idx);

    exc_cp0 #(
        .DEFAULT_CODE (DEFAULT_CODE),
        .SET_W        (SET_W),
        .RUN_BASE     (RUN_BASE),
        .BOOT_BASE    (BOOT_BASE),
        .RESET_VEC    (RESET_VEC)
    ) u_cp0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .kind        (win_kind),
        .pc          (fault_pc),
        .npc         (fault_npc),
        .we          (cp0_wr_en),
        .wsel        (cp0_wr_sel),
        .wdata       (cp0_wr_data),
        .rsel        (cp0_rd_sel),
        .rdata       (cp0_rd_data),
        .redir_valid (redirect_valid),
        .redir_pc    (redirect_pc)
    );

    // R2: the winner is the lowest set request bit.
    always_comb begin
        if (rst_n && take) begin
            assert_winner_R2: assert (fault_req[win_idx] && ((fault_req & ((17'(1) << win_idx) - 17'(1))) == '0));
        end
    end

endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] fault_req = '0;
    logic [31:0] fault_pc = '0;
    logic [31:0] fault_npc = '0;
    logic        cp0_wr_en = 1'b0;
    logic [1:0]  cp0_wr_sel = '0;
    logic [31:0] cp0_wr_data = '0;
    logic [1:0]  cp0_rd_sel = '0;
    logic [31:0] cp0_rd_data;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_pc(fault_pc),
        .fault_npc(fault_npc), .cp0_wr_en(cp0_wr_en), .cp0_wr_sel(cp0_wr_sel),
        .cp0_wr_data(cp0_wr_data), .cp0_rd_sel(cp0_rd_sel), .cp0_rd_data(cp0_rd_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        cp0_rd_sel = s;
        #1;
        v = cp0_rd_data;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cp0_wr_en = 1'b1; cp0_wr_sel = s; cp0_wr_data = d;
        @(negedge clk);
        cp0_wr_en = 1'b0;
    endtask

    // Request at a falling edge, sampled on the next rising edge; returns at
    // the falling edge after it, when the pulse is visible.
    task automatic fire(input logic [16:0] req, input logic [31:0] pc, input logic [31:0] npc);
        @(negedge clk);
        fault_req = req; fault_pc = pc; fault_npc = npc;
        @(negedge clk);
        fault_req = '0;
    endtask

    function automatic logic [4:0] exp_code(int i);
        case (i)
            3: return 5'd24;  7: return 5'd11;  8: return 5'd10;
            9: return 5'd8;  10: return 5'd9;  11: return 5'd13;
            12: return 5'd12; 13: return 5'd1; 16: return 5'd0;
            default: return 5'd30;
        endcase
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        chk("R1", "redirect_valid", {31'b0, redirect_valid}, 32'd0);
        rd(2'd0, v); chk("R1", "status", v, 32'h0040_0000);
        rd(2'd1, v); chk("R1", "cause", v, 32'h0);
        rd(2'd2, v); chk("R1", "epc", v, 32'h0);
        rd(2'd3, v); chk("R1", "srs", v, 32'h0);
    endtask

    task automatic t_boot_syscall;
        logic [31:0] v;
        fire(17'(1) << 9, 32'h1000, 32'h1004);
        chk("R9", "pulse", {31'b0, redirect_valid}, 32'd1);
        chk("R7", "boot vector", redirect_pc, 32'hBFC0_0380);
        rd(2'd0, v); chk("R3", "status exl", v, 32'h0040_0002);
        rd(2'd1, v); chk("R5", "cause sys", v, 32'h0000_0020);
        rd(2'd2, v); chk("R4", "epc no slot", v, 32'h1000);
        rd(2'd3, v); chk("R6", "srs held bev", v, 32'h0);
        @(negedge clk);
        chk("R9", "pulse drop", {31'b0, redirect_valid}, 32'd0);
    endtask

    task automatic t_nested_slot;
        logic [31:0] v;
        fire(17'(1) << 9, 32'h2004, 32'h3000);
        chk("R9", "pulse", {31'b0, redirect_valid}, 32'd1);
        rd(2'd0, v); chk("R3", "exl stays", v, 32'h0040_0002);
        rd(2'd1, v); chk("R4", "cause bd", v, 32'h8000_0020);
        rd(2'd2, v); chk("R4", "epc slot", v, 32'h2000);
    endtask

    task automatic t_rotation;
        logic [31:0] v;
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h0000_5002);
        rd(2'd3, v); chk("R10", "srs write", v, 32'h0000_5002);
        fire(17'(1) << 16, 32'h4000, 32'h4004);
        chk("R7", "run int vector", redirect_pc, 32'h8000_0000);
        rd(2'd3, v); chk("R6", "srs rotate", v, 32'h0000_5085);
        rd(2'd1, v); chk("R5", "cause int", v, 32'h0);
        rd(2'd0, v); chk("R3", "status", v, 32'h0000_0002);
        fire(17'(1) << 12, 32'h4100, 32'h4104);
        chk("R7", "run gen vector", redirect_pc, 32'h8000_0180);
        rd(2'd3, v); chk("R6", "srs held exl", v, 32'h0000_5085);
        rd(2'd1, v); chk("R5", "cause ov", v, 32'h0000_0030);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(2'd0, 32'h0);
        fire((17'(1) << 8) | (17'(1) << 12) | (17'(1) << 16), 32'h5000, 32'h5004);
        chk("R2", "ri wins vec", redirect_pc, 32'h8000_0180);
        rd(2'd1, v); chk("R2", "ri wins code", v, 32'h0000_0028);
        wr(2'd0, 32'h0);
        fire((17'(1) << 3) | (17'(1) << 8), 32'h5100, 32'h5104);
        rd(2'd1, v); chk("R2", "mcheck wins", v, 32'h0000_0060);
        fire((17'(1) << 2) | (17'(1) << 3), 32'h5200, 32'h5204);
        chk("R2", "nmi wins", redirect_pc, 32'hBFC0_0000);
        rd(2'd1, v); chk("R8", "nmi cause kept", v, 32'h0000_0060);
        rd(2'd2, v); chk("R8", "nmi epc kept", v, 32'h5100);
        fire((17'(1) << 0) | (17'(1) << 2), 32'h5300, 32'h5304);
        chk("R8", "reset vector", redirect_pc, 32'hBFC0_0000);
        rd(2'd0, v); chk("R8", "reset cu1", v, 32'h2000_0002);
        rd(2'd2, v); chk("R8", "reset epc kept", v, 32'h5100);
    endtask

    task automatic t_codes;
        logic [31:0] v;
        for (int i = 3; i <= 16; i++) begin
            wr(2'd0, 32'h0);
            fire(17'(1) << i, 32'h100 * i, 32'h100 * i + 32'd4);
            chk("R7", $sformatf("vector kind %0d", i), redirect_pc,
                32'h8000_0000 + ((i == 16) ? 32'h0 : 32'h180));
            rd(2'd1, v); chk("R5", $sformatf("code kind %0d", i), v, {25'b0, exp_code(i), 2'b00});
        end
    endtask

    task automatic t_resetlike_quiet;
        logic [31:0] s0, c0, e0, r0, v;
        wr(2'd0, 32'h0);
        rd(2'd0, s0); rd(2'd1, c0); rd(2'd2, e0); rd(2'd3, r0);
        for (int k = 1; k <= 2; k++) begin
            fire(17'(1) << k, 32'h6000, 32'h6100);
            chk("R8", "pulse", {31'b0, redirect_valid}, 32'd1);
            chk("R8", "reset vector", redirect_pc, 32'hBFC0_0000);
            rd(2'd0, v); chk("R8", "status kept", v, s0);
            rd(2'd1, v); chk("R8", "cause kept", v, c0);
            rd(2'd2, v); chk("R8", "epc kept", v, e0);
            rd(2'd3, v); chk("R8", "srs kept", v, r0);
        end
    endtask

    task automatic t_write_rules;
        logic [31:0] v, c0;
        @(negedge clk);
        cp0_wr_en = 1'b1; cp0_wr_sel = 2'd2; cp0_wr_data = 32'hDEAD_BEEF;
        fault_req = 17'(1) << 9; fault_pc = 32'h7000; fault_npc = 32'h7004;
        @(negedge clk);
        cp0_wr_en = 1'b0; fault_req = '0;
        chk("R10", "pulse on clash", {31'b0, redirect_valid}, 32'd1);
        rd(2'd2, v); chk("R10", "write dropped", v, 32'h7000);
        wr(2'd2, 32'h1234_5678);
        chk("R9", "no pulse on write", {31'b0, redirect_valid}, 32'd0);
        rd(2'd2, v); chk("R10", "epc write", v, 32'h1234_5678);
        rd(2'd1, c0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10", "cause ignores write", v, c0);
        wr(2'd0, 32'h2040_0002);
        rd(2'd0, v); chk("R10", "status write", v, 32'h2040_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot_syscall();
        t_nested_slot();
        t_rotation();
        t_priority();
        t_codes();
        t_resetlike_quiet();
        t_write_rules();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule